// File: doc/BRIEF.md
# CPU Hotplug Selector Register Window

This block is a 12-byte register window that manages many CPU slots through a single selector register. The host stores a CPU index in the selector. Every later access to the status, control, command and data locations then acts on that one CPU. For the selected slot, the host can read three flags: enabled, insert pending and remove pending. A control byte clears the selected slot's pending events. The platform raises those events on per-slot request inputs.

A command byte sets how the 32-bit data words behave. Command 0 scans all slots and moves the selector to the lowest slot that has a pending event; a data read then returns the selector. Command 3 exposes the selected CPU's 64-bit identifier. The low half appears at the data word and the high half at offset 0x0. Commands 1 and 2 latch an OS status-report event word and status word. Storing the status word raises a one-cycle notify pulse that carries both values.

A selector value at or above the slot count makes the window inert until a valid index is written. The selector is cleared only by the power-on reset. The ordinary reset leaves it untouched.

Top module: `cpu_hotplug_regs`

## Requirements
- R1: Only offsets 0x0, 0x4, 0x5 and 0x8 are decoded. Accesses at any other offset (0x1-0x3, 0x6, 0x7, 0x9-0xF) read as 0 and writes there change no state. Byte registers use `wdata[7:0]`/`rdata[7:0]`. Word registers use all 32 bits, least significant byte at the lowest offset.
- R2: A write at offset 0x0 stores the full 32-bit value into the selector, whatever that value is. The selector is visible at offset 0x8 while the command is 0.
- R3: While the selector is N_CPU or larger, every offset reads 0. Writes to 0x4, 0x5 and 0x8 are ignored. Writes to 0x0 still take effect.
- R4: `por_n` low sets the selector to 0. `rst_n` low leaves the selector value unchanged.
- R5: A read at 0x4 returns bit0 = selected CPU enabled, bit1 = insert pending and bit2 = remove pending, with bits 31:3 zero.
- R6: `ins_req[i]`/`rem_req[i]` set slot i's insert/remove flag. A control write at 0x4 clears the selected slot's insert flag when bit1 = 1 and its remove flag when bit2 = 1. Bit0 is ignored. A set and a clear in the same cycle leave the flag set.
- R7: Writing command 0 to 0x5 loads the selector with the lowest slot index whose insert or remove flag is set. If no flag is set, the selector and all flags stay unchanged.
- R8: A read at 0x8 returns the selector for command 0, bits 31:0 of the selected CPU identifier for command 3, and 0 for any other command byte.
- R9: A read at 0x0 returns bits 63:32 of the selected CPU identifier for command 3, and 0 otherwise.
- R10: A write at 0x8 stores `ost_event` under command 1 and `ost_status` under command 2. The command-2 write drives `ost_valid` high for exactly the next cycle, with both stored words on the outputs.
- R11: `rst_n` low clears all pending flags, the command byte (to 0), both status-report words and `ost_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears everything including the selector |
| rst_n | input | 1 | Ordinary reset, active low, keeps the selector |
| addr | input | 4 | Byte offset of the access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| cpu_enabled | input | N_CPU | Per-slot enabled indication |
| ins_req | input | N_CPU | Per-slot insert event request pulses |
| rem_req | input | N_CPU | Per-slot remove event request pulses |
| cpu_id | input | N_CPU*64 | Per-slot 64-bit identifiers, slot i at bits 64*i+63:64*i |
| ost_valid | output | 1 | One-cycle notify pulse after a status word write |
| ost_event | output | 32 | Stored status-report event word |
| ost_status | output | 32 | Stored status-report status word |

## Verification
Read data is combinational, so a read is due in the same cycle its offset is presented. The bench drives the offset at the falling edge and samples one nanosecond later. Writes, event requests and the scan command change state at the next rising edge. Their effects are therefore checked through reads at the falling edge that follows. The notify pulse and its two words are due in the cycle after the status write, and are sampled at that same falling edge. After a reset is released, the two-stage synchronizers delay internal release by two edges, and the bench waits three cycles before its first access.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int          DATA_W   = 32;
  localparam int          ID_W     = 64;
  localparam logic [3:0]  OFS_SEL  = 4'h0;
  localparam logic [3:0]  OFS_STAT = 4'h4;
  localparam logic [3:0]  OFS_CMD  = 4'h5;
  localparam logic [3:0]  OFS_DATA = 4'h8;
  localparam logic [7:0]  CMD_SCAN = 8'd0;
  localparam logic [7:0]  CMD_OSTE = 8'd1;
  localparam logic [7:0]  CMD_OSTS = 8'd2;
  localparam logic [7:0]  CMD_ID   = 8'd3;
endpackage

// File: rtl/hp_rst_sync.sv
module hp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/hp_event_flags.sv
module hp_event_flags #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  set_i,
  input  logic          clr_en,
  input  logic [IW-1:0] clr_idx,
  output logic [N-1:0]  flags_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] flags_d;

  // set dominates a clear aimed at the same slot
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic hit;
    assign hit        = clr_en && (clr_idx == IW'(g));
    assign flags_d[g] = set_i[g] | (flags_q[g] & ~hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/hp_pending_scan.sv
module hp_pending_scan #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          found,
  output logic [IW-1:0] idx
);
  // walk downward so the lowest pending slot is the last assignment
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/cpu_hotplug_regs.sv
module cpu_hotplug_regs
  import hp_pkg::*;
#(
  parameter int N_CPU = 8
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  rst_n,
  input  logic [3:0]            addr,
  input  logic                  wr_en,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic [N_CPU-1:0]      cpu_enabled,
  input  logic [N_CPU-1:0]      ins_req,
  input  logic [N_CPU-1:0]      rem_req,
  input  logic [N_CPU*ID_W-1:0] cpu_id,
  output logic                  ost_valid,
  output logic [DATA_W-1:0]     ost_event,
  output logic [DATA_W-1:0]     ost_status
);
  localparam int IW = (N_CPU > 1) ? $clog2(N_CPU) : 1;

  // reset synchronizers: selector domain vs. everything else
  logic por_sync_n, core_rst_n, core_arst_n;
  assign core_arst_n = por_n & rst_n;

  hp_rst_sync u_por_sync  (.clk(clk), .arst_n(por_n),       .srst_n(por_sync_n));
  hp_rst_sync u_core_sync (.clk(clk), .arst_n(core_arst_n), .srst_n(core_rst_n));

  // state
  logic [DATA_W-1:0] sel_q, sel_d;
  logic              sel_en;
  logic [7:0]        cmd_q;
  logic              cmd_en;
  logic [DATA_W-1:0] ev_q, st_q;
  logic              ev_en, st_en, ost_q;

  logic              sel_valid;
  logic [IW-1:0]     sel_idx;
  assign sel_valid = (sel_q < DATA_W'(N_CPU));
  assign sel_idx   = sel_q[IW-1:0];

  // access decode
  logic wr_sel, wr_ctl, wr_cmd, wr_dat, scan_go;
  assign wr_sel  = wr_en && (addr == OFS_SEL);
  assign wr_ctl  = wr_en && (addr == OFS_STAT) && sel_valid;
  assign wr_cmd  = wr_en && (addr == OFS_CMD)  && sel_valid;
  assign wr_dat  = wr_en && (addr == OFS_DATA) && sel_valid;
  assign scan_go = wr_cmd && (wdata[7:0] == CMD_SCAN);

  // per-slot event flags
  logic [N_CPU-1:0] ins_q, rem_q;

  hp_event_flags #(.N(N_CPU), .IW(IW)) u_ins_flags (
    .clk(clk), .rst_n(core_rst_n), .set_i(ins_req),
    .clr_en(wr_ctl && wdata[1]), .clr_idx(sel_idx), .flags_o(ins_q)
  );

  hp_event_flags #(.N(N_CPU), .IW(IW)) u_rem_flags (
    .clk(clk), .rst_n(core_rst_n), .set_i(rem_req),
    .clr_en(wr_ctl && wdata[2]), .clr_idx(sel_idx), .flags_o(rem_q)
  );

  // pending-event search
  logic          scan_hit;
  logic [IW-1:0] scan_idx;

  hp_pending_scan #(.N(N_CPU), .IW(IW)) u_scan (
    .pend(ins_q | rem_q), .found(scan_hit), .idx(scan_idx)
  );

  // identifier lanes
  logic [ID_W-1:0] id_arr [N_CPU];
  for (genvar g = 0; g < N_CPU; g++) begin : g_id
    assign id_arr[g] = cpu_id[g*ID_W +: ID_W];
  end

  logic [ID_W-1:0] id_sel;
  assign id_sel = id_arr[sel_idx];

  // next state
  always_comb begin
    sel_d  = sel_q;
    sel_en = 1'b0;
    if (wr_sel) begin
      sel_d  = wdata;
      sel_en = 1'b1;
    end else if (scan_go && scan_hit) begin
      sel_d  = DATA_W'(scan_idx);
      sel_en = 1'b1;
    end
  end

  assign cmd_en = wr_cmd;
  assign ev_en  = wr_dat && (cmd_q == CMD_OSTE);
  assign st_en  = wr_dat && (cmd_q == CMD_OSTS);

  // registers
  always_ff @(posedge clk or negedge por_sync_n) begin
    if (!por_sync_n)  sel_q <= '0;
    else if (sel_en)  sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      cmd_q <= CMD_SCAN;
      ev_q  <= '0;
      st_q  <= '0;
      ost_q <= 1'b0;
    end else begin
      if (cmd_en) cmd_q <= wdata[7:0];
      if (ev_en)  ev_q  <= wdata;
      if (st_en)  st_q  <= wdata;
      ost_q <= st_en;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (sel_valid) begin
      unique case (addr)
        OFS_SEL:  rdata = (cmd_q == CMD_ID) ? id_sel[ID_W-1:DATA_W] : '0;
        OFS_STAT: rdata = {29'b0, rem_q[sel_idx], ins_q[sel_idx], cpu_enabled[sel_idx]};
        OFS_DATA: begin
          if (cmd_q == CMD_SCAN)    rdata = sel_q;
          else if (cmd_q == CMD_ID) rdata = id_sel[DATA_W-1:0];
        end
        default:  rdata = '0;
      endcase
    end
  end

  assign ost_valid  = ost_q;
  assign ost_event  = ev_q;
  assign ost_status = st_q;
endmodule

// File: rtl/hp_regs_chk.sv
module hp_regs_chk #(
  parameter int N_CPU = 8
) (
  input logic             clk,
  input logic             core_rst_n,
  input logic [3:0]       addr,
  input logic             wr_en,
  input logic [7:0]       wbyte,
  input logic [31:0]      rdata,
  input logic [31:0]      sel_q,
  input logic [7:0]       cmd_q,
  input logic [N_CPU-1:0] pend,
  input logic             ost_valid
);
  logic invalid;
  assign invalid = (sel_q >= 32'(N_CPU));

  // R3
  invalid_sel_read_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    invalid |-> (rdata == 32'd0));

  // R3
  invalid_cmd_ignore_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && addr == 4'h5 && invalid) |=> $stable(cmd_q));

  // R5
  stat_upper_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr == 4'h4) |-> (rdata[31:3] == 29'd0));

  // R7
  scan_idle_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wr_en && addr == 4'h5 && wbyte == 8'd0 && !invalid && pend == '0) |=> $stable(sel_q));

  // R10
  ost_source_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    ost_valid |-> $past(wr_en && addr == 4'h8 && cmd_q == 8'd2 && !invalid));
endmodule

bind cpu_hotplug_regs hp_regs_chk #(.N_CPU(N_CPU)) u_chk (
  .clk(clk), .core_rst_n(core_rst_n), .addr(addr), .wr_en(wr_en),
  .wbyte(wdata[7:0]), .rdata(rdata), .sel_q(sel_q), .cmd_q(cmd_q),
  .pend(ins_q | rem_q), .ost_valid(ost_valid)
);

// File: tb/sim_cpu_hotplug_regs.sv
module sim_cpu_hotplug_regs;
  localparam int N = 8;

  logic            clk = 1'b0;
  logic            por_n, rst_n, wr_en;
  logic [3:0]      addr;
  logic [31:0]     wdata, rdata;
  logic [N-1:0]    cpu_enabled, ins_req, rem_req;
  logic [N*64-1:0] cpu_id;
  logic            ost_valid;
  logic [31:0]     ost_event, ost_status;

  cpu_hotplug_regs #(.N_CPU(N)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .cpu_enabled(cpu_enabled), .ins_req(ins_req),
    .rem_req(rem_req), .cpu_id(cpu_id), .ost_valid(ost_valid),
    .ost_event(ost_event), .ost_status(ost_status)
  );

  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // reference model
  logic [31:0] m_sel;
  logic [7:0]  m_cmd;
  logic [N-1:0] m_ins, m_rem;
  logic [31:0] m_ev, m_st;
  logic        m_pulse;
  logic [63:0] ids [N];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_rd(logic [3:0] a);
    logic [31:0] s;
    s = m_sel;
    if (s >= N) return 32'd0;
    case (a)
      4'h0: return (m_cmd == 8'd3) ? ids[s][63:32] : 32'd0;
      4'h4: return {29'd0, m_rem[s], m_ins[s], cpu_enabled[s]};
      4'h8: return (m_cmd == 8'd0) ? m_sel : (m_cmd == 8'd3) ? ids[s][31:0] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic model_wr(logic [3:0] a, logic [31:0] d);
    bit v;
    v = (m_sel < N);
    m_pulse = 1'b0;
    case (a)
      4'h0: m_sel = d;
      4'h4: if (v) begin
        if (d[1]) m_ins[m_sel] = 1'b0;
        if (d[2]) m_rem[m_sel] = 1'b0;
      end
      4'h5: if (v) begin
        m_cmd = d[7:0];
        if (d[7:0] == 8'd0) begin
          int hit;
          hit = -1;
          for (int i = N - 1; i >= 0; i--) if (m_ins[i] | m_rem[i]) hit = i;
          if (hit >= 0) m_sel = 32'(hit);
        end
      end
      4'h8: if (v) begin
        if (m_cmd == 8'd1) m_ev = d;
        else if (m_cmd == 8'd2) begin m_st = d; m_pulse = 1'b1; end
      end
      default: ;
    endcase
  endtask

  task automatic rd_chk(logic [3:0] a, string tag);
    @(negedge clk);
    addr  = a;
    wr_en = 1'b0;
    #1;
    check(tag, rdata, model_rd(a));
  endtask

  // one write cycle, optional same-cycle event requests
  task automatic wr(logic [3:0] a, logic [31:0] d,
                    logic [N-1:0] ins = '0, logic [N-1:0] rem = '0);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; ins_req = ins; rem_req = rem;
    model_wr(a, d);
    m_ins |= ins;
    m_rem |= rem;
    @(negedge clk);
    wr_en = 1'b0; ins_req = '0; rem_req = '0;
    check("R10 pulse", {31'd0, ost_valid}, {31'd0, m_pulse});
    if (m_pulse) begin
      check("R10 event", ost_event, m_ev);
      check("R10 status", ost_status, m_st);
    end
  endtask

  task automatic do_reset(bit por);
    @(negedge clk);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    m_ins = '0; m_rem = '0; m_cmd = 8'd0; m_ev = '0; m_st = '0; m_pulse = 1'b0;
    if (por) m_sel = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    por_n = 1'b0; rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    ins_req = '0; rem_req = '0; cpu_enabled = 8'b1010_0101;
    for (int g = 0; g < N; g++) begin
      ids[g] = {$urandom, $urandom};
      cpu_id[g*64 +: 64] = ids[g];
    end
    m_sel = '0; m_cmd = '0; m_ins = '0; m_rem = '0; m_ev = '0; m_st = '0; m_pulse = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R4, R11)
    rd_chk(4'h8, "R4 selector after power-on");
    rd_chk(4'h4, "R11 flags clear after reset");
    check("R11 ost_valid idle", {31'd0, ost_valid}, 32'd0);

    // scan ordering (R7, R6)
    wr(4'h0, 32'd0, 8'b0010_0000, 8'b0000_0100);
    wr(4'h5, 32'd0);
    rd_chk(4'h8, "R7 lowest pending slot");
    rd_chk(4'h4, "R5 status of slot 2");
    wr(4'h4, 32'h4);
    wr(4'h5, 32'd0);
    rd_chk(4'h8, "R7 next pending slot");
    wr(4'h4, 32'h3);
    rd_chk(4'h4, "R6 insert cleared, bit0 ignored");
    wr(4'h5, 32'd0);
    rd_chk(4'h8, "R7 no pending keeps selector");

    // set beats clear (R6)
    wr(4'h0, 32'd3);
    wr(4'h4, 32'h6, 8'b0000_1000, 8'b0000_1000);
    rd_chk(4'h4, "R6 same-cycle set wins");

    // identifier reads (R8, R9)
    wr(4'h5, 32'd3);
    rd_chk(4'h8, "R8 id low");
    rd_chk(4'h0, "R9 id high");

    // invalid selector (R3)
    wr(4'h0, 32'd8);
    rd_chk(4'h8, "R3 invalid read");
    wr(4'h5, 32'd0);
    wr(4'h0, 32'd1);
    rd_chk(4'h0, "R3 command untouched while invalid");
    wr(4'h0, 32'hFFFF_0001);
    wr(4'h4, 32'h6);
    wr(4'h0, 32'd3);
    rd_chk(4'h4, "R3 control ignored while invalid");

    // status-report words (R10)
    wr(4'h5, 32'd1);
    wr(4'h8, 32'hA5A5_0001);
    wr(4'h5, 32'd2);
    wr(4'h8, 32'h0000_BEEF);
    wr(4'h5, 32'd7);
    rd_chk(4'h8, "R8 other command reads 0");

    // reserved offsets (R1)
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h6, 32'hFFFF_FFFF);
    rd_chk(4'h6, "R1 reserved read");
    rd_chk(4'h5, "R1 command byte reads 0");

    // ordinary reset keeps selector (R4)
    wr(4'h0, 32'd5);
    do_reset(1'b0);
    rd_chk(4'h8, "R4 selector kept over rst_n");
    rd_chk(4'h4, "R11 flags cleared by rst_n");
    check("R11 ost_event cleared", ost_event, 32'd0);
    do_reset(1'b1);
    rd_chk(4'h8, "R4 por clears selector");

    // constrained random
    for (int it = 0; it < 3000; it++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0: wr(4'h0, ($urandom % 12 == 0) ? $urandom : ($urandom % (N + 2)));
        1: wr(4'h4, $urandom % 256);
        2: begin
          logic [7:0] c;
          c = ($urandom % 6 == 5) ? 8'($urandom) : 8'($urandom % 5);
          wr(4'h5, {24'd0, c});
        end
        3: wr(4'h8, $urandom);
        4: wr(4'hC, $urandom, N'($urandom & $urandom & $urandom), N'($urandom & $urandom & $urandom));
        5: begin
          logic [3:0] ra;
          ra = 4'($urandom);
          if (ra == 4'h0 || ra == 4'h4 || ra == 4'h5 || ra == 4'h8) ra = 4'h7;
          wr(ra, $urandom);
        end
        6: begin @(negedge clk); cpu_enabled = N'($urandom); end
        default: for (int k = 0; k < 16; k++) rd_chk(4'(k), "R1 R2 R5 R8 R9 random read");
      endcase
      rd_chk(4'($urandom), "R2 R3 R8 random read");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule